// File: doc/BRIEF.md
# Rail Overvoltage/Undervoltage Fault Monitor

This block watches the digitized output voltages of several supply rails on a card. Each rail has a nominal code. From that code the block derives two pairs of limits. The outer pair sits at about ±10 % of nominal and shuts the rails down. The inner pair sits at about ±5 % and only raises a warning. A single sample port carries conversion results from all rails. Each result comes with a valid strobe and the index of its rail. Each limit has its own consecutive-sample qualification count. The undervoltage counts are deliberately much longer than the overvoltage counts, so that slow sag is tolerated while fast overshoot is caught early.

A qualified shutdown fault on any rail raises a global shutdown request. An overvoltage fault also asks for the upstream intermediate-bus converter to be switched off. After an overvoltage fault no restart is attempted, and the fault stays latched until an explicit clear. After an undervoltage fault the block waits a fixed time and then pulses a restart request. It does this only a limited number of times, and after that the fault stays latched until cleared. Undervoltage checking on a rail is suppressed while the sequencer reports that rail as not yet on and settled.

Top module: `rail_fault_monitor`

## Requirements
- R1: When `cfg_load` is high at a clock edge, the limits of every rail are captured from `nom_code` (rail r in bits [r*VW +: VW]). With t = n>>4 + n>>5 + n>>8 + n>>9 and f = n>>5 + n>>6 + n>>9 + n>>10, the trip limits are n+t and n−t, and the warning limits are n+f and n−f. A code is overvoltage only if it is strictly above the upper limit, and undervoltage only if it is strictly below the lower limit.
- R2: `warn_ov[r]` or `warn_uv[r]` rises after WARN_OV_QUAL or WARN_UV_QUAL consecutive violating samples of rail r. It falls with the first sample of that rail that is back inside the limit.
- R3: A single in-limit sample of a rail restarts that rail's qualification count, so only unbroken runs of violations qualify.
- R4: A shutdown fault latches after TRIP_OV_QUAL consecutive samples above the upper trip limit, or after TRIP_UV_QUAL consecutive samples below the lower trip limit.
- R5: While `rail_on[r]` is low, undervoltage samples of rail r neither warn, nor trip, nor count toward qualification.
- R6: After reset all outputs are low. A latched fault sets only that rail's bit of `trip_flags` and raises `shutdown_req`.
- R7: An overvoltage trip raises `bus_kill_req`. It never leads to a restart pulse, and it stays latched until `fault_clear`.
- R8: After an undervoltage-only shutdown, `restart_req` pulses for one cycle RESTART_WAIT cycles after `shutdown_req` is first seen high. In that same cycle `shutdown_req` falls.
- R9: At most MAX_RESTARTS restarts are issued. Any later undervoltage trip stays latched until `fault_clear`, which also restores the restart allowance.
- R10: Samples tagged for one rail neither advance nor reset another rail's qualification counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Capture limits from nominal codes |
| nom_code | input | N_RAILS*VW | Packed nominal codes, rail r at [r*VW +: VW] |
| rail_on | input | N_RAILS | Rail enabled and settled (enables UV checks) |
| smp_valid | input | 1 | Sample strobe |
| smp_rail | input | IW | Rail index of the sample |
| smp_code | input | VW | Voltage code of the sample |
| fault_clear | input | 1 | Clear latched faults and restart allowance |
| warn_ov | output | N_RAILS | Per-rail overvoltage warning |
| warn_uv | output | N_RAILS | Per-rail undervoltage warning |
| trip_flags | output | N_RAILS | Per-rail latched shutdown fault |
| shutdown_req | output | 1 | Shut all rails down |
| bus_kill_req | output | 1 | Switch off upstream bus converter |
| restart_req | output | 1 | One-cycle controlled restart request |

## Verification
The hardest state to reach is the exhausted restart allowance. It needs several complete undervoltage-trip, wait and restart rounds in a row, each with an unbroken run of low samples on a rail that is reported on. The bench repeats the same undervoltage burst, and each time it waits for the restart pulse and times it. After the last allowed restart, one more burst must leave the fault latched past the wait time. Only then does the clear prove that the allowance comes back.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
   typedef enum logic [1:0] {
      POL_RUN  = 2'd0,
      POL_WAIT = 2'd1,
      POL_LOCK = 2'd2
   } pol_state_t;

   function automatic int unsigned cnt_w(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction
endpackage

// File: rtl/rfm_limits.sv
module rfm_limits #(
   parameter int unsigned VW        = 10,
   parameter bit          FINE_STEP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [VW-1:0] nom,
   output logic [VW:0]   ov_trip,
   output logic [VW:0]   uv_trip,
   output logic [VW:0]   ov_warn,
   output logic [VW:0]   uv_warn
);
   localparam int unsigned XW = VW + 1;

   logic [XW-1:0] n_x;
   logic [XW-1:0] tenth;
   logic [XW-1:0] twentieth;

   assign n_x = {1'b0, nom};

   generate
      if (FINE_STEP) begin : g_fine
         assign tenth     = (n_x >> 4) + (n_x >> 5) + (n_x >> 8) + (n_x >> 9);
         assign twentieth = (n_x >> 5) + (n_x >> 6) + (n_x >> 9) + (n_x >> 10);
      end else begin : g_coarse
         assign tenth     = (n_x >> 4) + (n_x >> 5);
         assign twentieth = (n_x >> 5) + (n_x >> 6);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_trip <= '1;
         ov_warn <= '1;
         uv_trip <= '0;
         uv_warn <= '0;
      end else if (load) begin
         ov_trip <= n_x + tenth;
         uv_trip <= n_x - tenth;
         ov_warn <= n_x + twentieth;
         uv_warn <= n_x - twentieth;
      end
   end

   // R1: the limits stay nested around nominal once they are loaded
   a_r1_nested: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load) |-> (ov_trip >= ov_warn) && (uv_trip <= uv_warn));
endmodule

// File: rtl/rfm_qual.sv
module rfm_qual #(
   parameter int unsigned QUAL = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flush,
   input  logic en,
   input  logic hit,
   input  logic viol,
   output logic qualified
);
   localparam int unsigned CW = rfm_pkg::cnt_w(QUAL);
   localparam logic [CW-1:0] QMAX = CW'(QUAL);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (flush || !en)   cnt <= '0;
      else if (hit) begin
         if (!viol)            cnt <= '0;
         else if (cnt != QMAX) cnt <= cnt + 1'b1;
      end
   end

   assign qualified = (cnt == QMAX);

   // R5: a disabled check holds no count
   a_r5_masked_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt == '0));
   // R3: an in-limit sample of this rail breaks the run
   a_r3_run_break: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !viol) |=> !qualified);
   // R10: without a sample of this rail the count never grows
   a_r10_no_foreign: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/rfm_policy.sv
module rfm_policy #(
   parameter int unsigned N_RAILS      = 4,
   parameter int unsigned MAX_RESTARTS = 2,
   parameter int unsigned RESTART_WAIT = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_RAILS-1:0] ov_q,
   input  logic [N_RAILS-1:0] uv_q,
   input  logic               fault_clear,
   output logic [N_RAILS-1:0] trip_flags,
   output logic               shutdown_req,
   output logic               bus_kill_req,
   output logic               restart_req,
   output logic               flush
);
   import rfm_pkg::*;

   localparam int unsigned RCW = cnt_w(MAX_RESTARTS);
   localparam int unsigned WCW = cnt_w(RESTART_WAIT);
   localparam logic [RCW-1:0] RMAX  = RCW'(MAX_RESTARTS);
   localparam logic [WCW-1:0] WLAST = WCW'(RESTART_WAIT - 1);

   logic [N_RAILS-1:0] ov_lat;
   logic [N_RAILS-1:0] uv_lat;
   logic [RCW-1:0]     n_restarts;
   logic [WCW-1:0]     wait_cnt;
   logic               fire;
   logic               any_lat;
   logic               any_ov;
   pol_state_t         state;

   assign any_lat = |(ov_lat | uv_lat);
   assign any_ov  = |ov_lat || |ov_q;
   assign fire    = (state == POL_WAIT) && !any_ov && (wait_cnt == WLAST) && !fault_clear;
   assign flush   = fire || fault_clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_lat      <= '0;
         uv_lat      <= '0;
         n_restarts  <= '0;
         wait_cnt    <= '0;
         restart_req <= 1'b0;
         state       <= POL_RUN;
      end else begin
         restart_req <= fire;
         if (fault_clear) begin
            ov_lat     <= '0;
            uv_lat     <= '0;
            n_restarts <= '0;
            wait_cnt   <= '0;
            state      <= POL_RUN;
         end else begin
            ov_lat <= ov_lat | ov_q;
            uv_lat <= fire ? '0 : (uv_lat | uv_q);
            unique case (state)
               POL_RUN: begin
                  wait_cnt <= '0;
                  if (any_lat) begin
                     if (any_ov || n_restarts == RMAX) state <= POL_LOCK;
                     else begin
                        state    <= POL_WAIT;
                        wait_cnt <= WCW'(1);
                     end
                  end
               end
               POL_WAIT: begin
                  if (any_ov) state <= POL_LOCK;
                  else if (fire) begin
                     state      <= POL_RUN;
                     wait_cnt   <= '0;
                     n_restarts <= n_restarts + 1'b1;
                  end else wait_cnt <= wait_cnt + 1'b1;
               end
               default: state <= POL_LOCK;
            endcase
         end
      end
   end

   assign trip_flags   = ov_lat | uv_lat;
   assign shutdown_req = any_lat;
   assign bus_kill_req = |ov_lat;

   // R8: restart request lasts one cycle
   a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |=> !restart_req);
   // R7: no restart while the bus converter is being killed
   a_r7_no_restart_ov: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |-> !bus_kill_req);
   // R7: overvoltage latch persists until clear
   a_r7_kill_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_kill_req && !fault_clear) |=> bus_kill_req);
   // R9: restart count never exceeds its limit
   a_r9_limit: assert property (@(posedge clk) disable iff (!rst_n)
      n_restarts <= RMAX);
   // R8: a restart drops the shutdown request
   a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |-> !shutdown_req);
endmodule

// File: rtl/rail_fault_monitor.sv
module rail_fault_monitor #(
   parameter int unsigned N_RAILS      = 4,
   parameter int unsigned VW           = 10,
   parameter int unsigned IW           = (N_RAILS < 2) ? 1 : $clog2(N_RAILS),
   parameter int unsigned WARN_OV_QUAL = 3,
   parameter int unsigned TRIP_OV_QUAL = 4,
   parameter int unsigned WARN_UV_QUAL = 6,
   parameter int unsigned TRIP_UV_QUAL = 10,
   parameter int unsigned MAX_RESTARTS = 2,
   parameter int unsigned RESTART_WAIT = 20,
   parameter bit          FINE_STEP    = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_load,
   input  logic [N_RAILS*VW-1:0] nom_code,
   input  logic [N_RAILS-1:0]    rail_on,
   input  logic                  smp_valid,
   input  logic [IW-1:0]         smp_rail,
   input  logic [VW-1:0]         smp_code,
   input  logic                  fault_clear,
   output logic [N_RAILS-1:0]    warn_ov,
   output logic [N_RAILS-1:0]    warn_uv,
   output logic [N_RAILS-1:0]    trip_flags,
   output logic                  shutdown_req,
   output logic                  bus_kill_req,
   output logic                  restart_req
);
   generate
      if (N_RAILS < 1 || VW < 4) begin : g_bad_size
         $error("rail_fault_monitor: N_RAILS must be >= 1 and VW >= 4");
      end
      if ((1 << IW) < N_RAILS) begin : g_bad_iw
         $error("rail_fault_monitor: IW too narrow for N_RAILS");
      end
      if (TRIP_UV_QUAL <= TRIP_OV_QUAL) begin : g_bad_asym
         $error("rail_fault_monitor: UV qualification must exceed OV qualification");
      end
      if (WARN_OV_QUAL < 1 || TRIP_OV_QUAL < 1 || RESTART_WAIT < 2) begin : g_bad_time
         $error("rail_fault_monitor: qualification counts >= 1 and RESTART_WAIT >= 2");
      end
   endgenerate

   localparam int unsigned XW = VW + 1;

   logic [N_RAILS-1:0] ov_trip_q;
   logic [N_RAILS-1:0] uv_trip_q;
   logic               flush;
   logic [XW-1:0]      code_x;

   assign code_x = {1'b0, smp_code};

   generate
      for (genvar r = 0; r < N_RAILS; r++) begin : g_rail
         logic [XW-1:0] lim_ovt, lim_uvt, lim_ovw, lim_uvw;
         logic          hit;

         assign hit = smp_valid && (smp_rail == IW'(r));

         rfm_limits #(.VW(VW), .FINE_STEP(FINE_STEP)) u_lim (
            .clk(clk), .rst_n(rst_n), .load(cfg_load),
            .nom(nom_code[r*VW +: VW]),
            .ov_trip(lim_ovt), .uv_trip(lim_uvt),
            .ov_warn(lim_ovw), .uv_warn(lim_uvw));

         rfm_qual #(.QUAL(WARN_OV_QUAL)) u_ovw (
            .clk(clk), .rst_n(rst_n), .flush(flush), .en(1'b1), .hit(hit),
            .viol(code_x > lim_ovw), .qualified(warn_ov[r]));

         rfm_qual #(.QUAL(TRIP_OV_QUAL)) u_ovt (
            .clk(clk), .rst_n(rst_n), .flush(flush), .en(1'b1), .hit(hit),
            .viol(code_x > lim_ovt), .qualified(ov_trip_q[r]));

         rfm_qual #(.QUAL(WARN_UV_QUAL)) u_uvw (
            .clk(clk), .rst_n(rst_n), .flush(flush), .en(rail_on[r]), .hit(hit),
            .viol(code_x < lim_uvw), .qualified(warn_uv[r]));

         rfm_qual #(.QUAL(TRIP_UV_QUAL)) u_uvt (
            .clk(clk), .rst_n(rst_n), .flush(flush), .en(rail_on[r]), .hit(hit),
            .viol(code_x < lim_uvt), .qualified(uv_trip_q[r]));
      end
   endgenerate

   rfm_policy #(
      .N_RAILS(N_RAILS), .MAX_RESTARTS(MAX_RESTARTS), .RESTART_WAIT(RESTART_WAIT)
   ) u_pol (
      .clk(clk), .rst_n(rst_n),
      .ov_q(ov_trip_q), .uv_q(uv_trip_q), .fault_clear(fault_clear),
      .trip_flags(trip_flags), .shutdown_req(shutdown_req),
      .bus_kill_req(bus_kill_req), .restart_req(restart_req), .flush(flush));

   // R5: no undervoltage warning on a rail reported off
   a_r5_no_warn_off: assert property (@(posedge clk) disable iff (!rst_n)
      !rail_on |=> ((warn_uv & ~$past(rail_on)) == '0));
   // R6: the global request follows the per-rail flags
   a_r6_global: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|trip_flags) |-> shutdown_req);
endmodule

// File: tb/rail_fault_monitor_tb_top.sv
module rail_fault_monitor_tb_top;
   localparam int N = 4, VW = 10, IW = 2;
   localparam int WOV = 3, TOV = 4, WUV = 6, TUV = 10, MAXR = 2, RW = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_load = 1'b0;
   logic [N*VW-1:0] nom_code;
   logic [N-1:0]    rail_on = '0;
   logic            smp_valid = 1'b0;
   logic [IW-1:0]   smp_rail = '0;
   logic [VW-1:0]   smp_code = '0;
   logic            fault_clear = 1'b0;
   logic [N-1:0]    warn_ov, warn_uv, trip_flags;
   logic            shutdown_req, bus_kill_req, restart_req;

   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   rail_fault_monitor #(
      .N_RAILS(N), .VW(VW), .IW(IW), .WARN_OV_QUAL(WOV), .TRIP_OV_QUAL(TOV),
      .WARN_UV_QUAL(WUV), .TRIP_UV_QUAL(TUV), .MAX_RESTARTS(MAXR), .RESTART_WAIT(RW)
   ) dut_i (.*);

   function automatic int tenth(input int n);
      return (n >> 4) + (n >> 5) + (n >> 8) + (n >> 9);
   endfunction
   function automatic int twentieth(input int n);
      return (n >> 5) + (n >> 6) + (n >> 9) + (n >> 10);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input int rail, input int code, input int times);
      for (int i = 0; i < times; i++) begin
         @(negedge clk);
         smp_valid = 1'b1; smp_rail = IW'(rail); smp_code = VW'(code);
         @(negedge clk);
         smp_valid = 1'b0;
      end
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic do_clear();
      @(negedge clk); fault_clear = 1'b1;
      @(negedge clk); fault_clear = 1'b0;
      settle();
   endtask

   // returns cycles from first shutdown to restart pulse, -1 on timeout
   task automatic time_restart(output int k);
      int w = 0;
      k = -1;
      while (!shutdown_req && w < 50) begin @(negedge clk); w++; end
      for (int c = 1; c <= RW + 40; c++) begin
         @(negedge clk);
         if (restart_req) begin
            k = c;
            chk("R8 shutdown drops with restart", int'(shutdown_req), 0);
            break;
         end
      end
   endtask

   task automatic t_reset();
      chk("R6 reset warn_ov", int'(warn_ov), 0);
      chk("R6 reset warn_uv", int'(warn_uv), 0);
      chk("R6 reset trips", int'(trip_flags), 0);
      chk("R6 reset shutdown", int'(shutdown_req), 0);
      chk("R6 reset kill", int'(bus_kill_req), 0);
      chk("R6 reset restart", int'(restart_req), 0);
   endtask

   task automatic t_limits();   // R1 R2 on rail 0, nominal 500
      int ow = 500 + twentieth(500), uw = 500 - twentieth(500);
      send(0, ow, WOV + 2); settle();
      chk("R1 ov warn edge not exceeded", int'(warn_ov[0]), 0);
      send(0, ow + 1, WOV - 1); settle();
      chk("R2 ov warn before count", int'(warn_ov[0]), 0);
      send(0, ow + 1, 1); settle();
      chk("R2 ov warn raised", int'(warn_ov[0]), 1);
      send(0, 500, 1); settle();
      chk("R2 ov warn falls", int'(warn_ov[0]), 0);
      send(0, uw, WUV + 2); settle();
      chk("R1 uv warn edge not below", int'(warn_uv[0]), 0);
      send(0, uw - 1, WUV); settle();
      chk("R2 uv warn raised", int'(warn_uv[0]), 1);
      chk("R2 no trip from warn", int'(shutdown_req), 0);
      send(0, 500, 1); settle();
      chk("R2 uv warn falls", int'(warn_uv[0]), 0);
   endtask

   task automatic t_run_break();   // R3 R4 R7 on rail 1, nominal 400
      int k;
      int ot = 400 + tenth(400);
      send(1, ot + 1, TOV - 1); send(1, 400, 1); send(1, ot + 1, TOV - 1); settle();
      chk("R3 broken run no trip", int'(shutdown_req), 0);
      send(1, ot + 1, 1); settle();
      chk("R4 ov trip flags", int'(trip_flags), 4'b0010);
      chk("R7 kill raised", int'(bus_kill_req), 1);
      time_restart(k);
      chk("R7 no restart after ov", k, -1);
      chk("R7 still latched", int'(trip_flags), 4'b0010);
      do_clear();
      chk("R7 clear drops kill", int'(bus_kill_req), 0);
      chk("R7 clear drops shutdown", int'(shutdown_req), 0);
   endtask

   task automatic t_mask_and_restart();   // R5 R4 R6 R8 on rail 2, nominal 600
      int k;
      int ut = 600 - tenth(600);
      send(2, ut - 100, TUV + 2); settle();
      chk("R5 masked no trip", int'(shutdown_req), 0);
      chk("R5 masked no warn", int'(warn_uv[2]), 0);
      rail_on[2] = 1'b1;
      send(2, ut - 100, TUV - 1); settle();
      chk("R4 uv not yet", int'(shutdown_req), 0);
      send(2, ut - 100, 1);
      time_restart(k);
      chk("R8 restart delay", k, RW);
      chk("R6 only rail2 flagged earlier cleared", int'(trip_flags), 0);
   endtask

   task automatic t_isolation();   // R10 R6 on rail 3, nominal 800
      int ot = 800 + tenth(800);
      for (int i = 0; i < TOV - 1; i++) begin
         send(3, ot + 1, 1); send(0, 500, 1);
      end
      settle();
      chk("R10 foreign samples keep run", int'(shutdown_req), 0);
      send(3, ot + 1, 1); settle();
      chk("R10 R6 only rail3 flagged", int'(trip_flags), 4'b1000);
      do_clear();
   endtask

   task automatic t_limit_restarts();   // R9 on rail 2
      int k;
      int ut = 600 - tenth(600);
      for (int i = 0; i < MAXR; i++) begin
         send(2, ut - 1, TUV);
         time_restart(k);
         chk("R9 allowed restart", k, RW);
      end
      send(2, ut - 1, TUV);
      time_restart(k);
      chk("R9 exhausted no restart", k, -1);
      chk("R9 fault held", int'(trip_flags), 4'b0100);
      chk("R9 no kill for uv", int'(bus_kill_req), 0);
      do_clear();
      chk("R9 clear releases", int'(shutdown_req), 0);
      send(2, ut - 1, TUV);
      time_restart(k);
      chk("R9 allowance restored", k, RW);
   endtask

   initial begin
      nom_code = {VW'(800), VW'(600), VW'(400), VW'(500)};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_reset();
      @(negedge clk); cfg_load = 1'b1;
      @(negedge clk); cfg_load = 1'b0;
      rail_on = 4'b1011;
      settle();
      t_limits();
      t_run_break();
      t_mask_and_restart();
      t_isolation();
      t_limit_restarts();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule